// File: doc/BRIEF.md
# Machine status and interrupt control registers

This block holds the privileged status and interrupt-control registers of one hart. A core's CSR unit drives one access per cycle into it: an address, a read strobe, a write strobe with write data, and the current privilege level. Read data comes back combinationally in the same cycle. A write lands at the next rising clock edge. Every write passes through per-field masks and legalisation. Derived fields, such as the dirty summary bit and the fixed register-width fields, are computed at read time.

The supervisor status, pending and enable registers have no storage of their own. They are masked windows onto the machine registers and onto the interrupt delegation mask. The block also presents its live machine-level values on plain output pins so that trap and interrupt logic can use them directly. Pending bits driven by hardware (software, timer and external interrupt lines, and one coprocessor line) enter through a level input.

The access port is a control transaction, not a stream. It has no valid/ready pair and never applies back-pressure. An access is complete in the cycle it is presented. An access that is not permitted raises the illegal flag in that same cycle, returns zero and changes nothing.

Top module: `hart_status_csrs`

## Requirements
- R1: The top bit of the machine status register (bit XLEN-1) reads 1 exactly when the float-state field (bits 14:13) or the extension-state field (bits 16:15) holds 2'b11. The supervisor status view shows the same bit at its own bit XLEN-1.
- R2: With XLEN=64, the user-width field (bits 33:32) and the supervisor-width field (bits 35:34) of machine status always read 2, whatever is written.
- R3: Machine status stores only these bits, and every other bit reads 0 apart from those in R1 and R2: 1, 3, 5, 7, 8, 12:11, 14:13, 16:15, 17, 18, 19, 20, 21 and 22. Bits 16:15 are storable only when HAS_XEXT=1. Writing all ones therefore reads 64'h8000_000A_007F_F9AA.
- R4: Software can write only bits 1 and 5 of the machine pending register (0x344). Bits 3, 7, 9, 11 and 12 read the matching bits of `hw_irq`, and every other bit reads 0.
- R5: The interrupt delegation register (0x303) keeps only bits 1, 5, 9 and 12. The machine enable register (0x304) keeps only bits 1, 3, 5, 7, 9, 11 and 12.
- R6: The supervisor enable (0x104) and supervisor pending (0x144) registers read as the machine enable and pending registers ANDed with the delegation mask. A supervisor enable write changes only delegated bits. A supervisor pending write changes only bit 1, and only when bit 1 is delegated.
- R7: A write to the supervisor trap vector (0x105) clears bits 1:0. A write to the machine trap vector (0x305) clears bit 1 and keeps bit 0.
- R8: The ISA register (0x301) resets to {MXL, 0, MAX_EXT}, with MXL=2 for 64-bit. Only the letter bits A(0), C(2), D(3), F(5) and M(12) that MAX_EXT contains may change. A write with bit 5 clear also clears bit 3.
- R9: Supervisor status (0x100) reads bits 1, 5, 8, 14:13, 16:15, 18 and 33:32 of machine status, plus the summary bit. A write to it reaches only machine-status bits 1, 5, 8, 14:13, 16:15, 18 and 19.
- R10: The vendor (0xF11), architecture (0xF12) and implementation (0xF13) ID registers read 0. The hart ID register (0xF14) reads HART_ID.
- R11: `csr_illegal` rises in the cycle of an access in three cases: the address is not implemented, `priv_lvl` is below address bits 9:8, or a write targets an address whose bits 11:10 are 2'b11. Such an access changes no register and reads 0.
- R12: The exception delegation register (0x302) keeps only the bits set in EXC_DELEG_MASK (default 16'hB3FF).
- R13: After reset, machine status reads only its R2 fields, the ISA register reads its R8 reset value, and all other registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe, applied at the next rising edge |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| hw_irq | input | 13 | Hardware pending lines; bits 3, 7, 9, 11, 12 are used |
| csr_rdata | output | XLEN | Read data; 0 when not reading or illegal |
| csr_illegal | output | 1 | Access not permitted this cycle |
| mstatus_o | output | XLEN | Machine status as read |
| misa_o | output | XLEN | ISA register |
| medeleg_o | output | XLEN | Exception delegation |
| mideleg_o | output | XLEN | Interrupt delegation |
| mie_o | output | XLEN | Machine interrupt enables |
| mip_o | output | XLEN | Machine interrupt pending |
| mtvec_o | output | XLEN | Machine trap vector |
| stvec_o | output | XLEN | Supervisor trap vector |

## Verification
The bench targets the summary bit for each of the extension-state and float-state fields. A design that tested only one field, or sampled the field before the write, would show a wrong top bit. It probes supervisor pending writes with bit 1 undelegated and with the timer bit delegated. A design that forgot the extra pending-write limit would let the timer bit through, and one that ignored delegation would clear bit 1. It writes the ISA register with F clear and D set, which a design lacking the dependency would accept as D=1. It also drives privilege-denied and read-only writes and reads the target back, which catches a design that gates the flag but not the write.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  localparam int unsigned IRQW = 13;

  // register addresses (decoded by software, so they follow the common map)
  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_SIE     = 12'h104;
  localparam logic [11:0] A_STVEC   = 12'h105;
  localparam logic [11:0] A_SIP     = 12'h144;
  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_MISA    = 12'h301;
  localparam logic [11:0] A_MEDELEG = 12'h302;
  localparam logic [11:0] A_MIDELEG = 12'h303;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_MIP     = 12'h344;
  localparam logic [11:0] A_VENDOR  = 12'hF11;
  localparam logic [11:0] A_ARCH    = 12'hF12;
  localparam logic [11:0] A_IMPL    = 12'hF13;
  localparam logic [11:0] A_HART    = 12'hF14;

  // status field masks, all below bit 32
  localparam logic [31:0] ST_BASE_WMASK = 32'h007E_79AA;
  localparam logic [31:0] ST_XS_MASK    = 32'h0001_8000;
  localparam logic [31:0] SV_WMASK      = 32'h000D_E122;
  localparam logic [31:0] SV_RMASK      = 32'h0005_E122;

  // interrupt bit masks
  localparam logic [IRQW-1:0] IRQ_DELEGABLE = 13'h1222;
  localparam logic [IRQW-1:0] IRQ_EN_WMASK  = 13'h1AAA;
  localparam logic [IRQW-1:0] IRQ_SW_PEND   = 13'h0022;
  localparam logic [IRQW-1:0] IRQ_HW_PEND   = 13'h1A88;
  localparam logic [IRQW-1:0] IRQ_SSOFT     = 13'h0002;

  // ISA letters that software may toggle: M, F, D, C, A
  localparam logic [25:0] ISA_TOGGLE = 26'h000102D;

  typedef enum logic [3:0] {
    R_NONE, R_MSTATUS, R_MISA, R_MEDELEG, R_MIDELEG, R_MIE, R_MTVEC, R_MIP,
    R_SSTATUS, R_SIE, R_STVEC, R_SIP, R_VENDOR, R_ARCH, R_IMPL, R_HART
  } reg_id_e;

  function automatic reg_id_e csr_lookup(input logic [11:0] a);
    case (a)
      A_MSTATUS: return R_MSTATUS;
      A_MISA:    return R_MISA;
      A_MEDELEG: return R_MEDELEG;
      A_MIDELEG: return R_MIDELEG;
      A_MIE:     return R_MIE;
      A_MTVEC:   return R_MTVEC;
      A_MIP:     return R_MIP;
      A_SSTATUS: return R_SSTATUS;
      A_SIE:     return R_SIE;
      A_STVEC:   return R_STVEC;
      A_SIP:     return R_SIP;
      A_VENDOR:  return R_VENDOR;
      A_ARCH:    return R_ARCH;
      A_IMPL:    return R_IMPL;
      A_HART:    return R_HART;
      default:   return R_NONE;
    endcase
  endfunction

endpackage

// File: rtl/hsc_status.sv
module hsc_status
  import hsc_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter bit          HAS_XEXT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_m,
  input  logic            we_s,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] mstatus_rd,
  output logic [XLEN-1:0] sstatus_rd
);
  localparam logic [31:0]     M_MASK32 = ST_BASE_WMASK | (HAS_XEXT ? ST_XS_MASK : 32'h0);
  localparam logic [XLEN-1:0] M_WMASK  = XLEN'(M_MASK32);
  localparam logic [XLEN-1:0] S_WMASK  = XLEN'(SV_WMASK & M_MASK32);
  localparam logic [XLEN-1:0] S_RMASK  = XLEN'(SV_RMASK);

  logic [XLEN-1:0] st_q;
  logic [XLEN-1:0] width_all, width_user;
  logic            dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= '0;
    else if (we_m) st_q <= wdata & M_WMASK;
    else if (we_s) st_q <= (st_q & ~S_WMASK) | (wdata & S_WMASK);
  end

  // width fields exist only in the 64-bit layout
  generate
    if (XLEN == 64) begin : g_wide
      assign width_all  = 64'h0000_000A_0000_0000;
      assign width_user = 64'h0000_0002_0000_0000;
    end else begin : g_narrow
      assign width_all  = '0;
      assign width_user = '0;
    end
  endgenerate

  assign dirty = (&st_q[14:13]) | (&st_q[16:15]);

  always_comb begin
    mstatus_rd = st_q | width_all;
    mstatus_rd[XLEN-1] = dirty;
    sstatus_rd = (st_q & S_RMASK) | width_user;
    sstatus_rd[XLEN-1] = dirty;
  end

  // R1: float-state all ones written -> summary bit reads 1
  assert_sd_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we_m && wdata[14:13] == 2'b11) |=> (mstatus_rd[XLEN-1] && sstatus_rd[XLEN-1]));
  // R1: neither state field all ones -> summary bit clear
  assert_sd_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we_m && wdata[14:13] != 2'b11 && wdata[16:15] != 2'b11) |=> !mstatus_rd[XLEN-1]);
endmodule

// File: rtl/hsc_irq.sv
module hsc_irq
  import hsc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_mip,
  input  logic            we_mie,
  input  logic            we_deleg,
  input  logic            we_sip,
  input  logic            we_sie,
  input  logic [IRQW-1:0] wd,
  input  logic [IRQW-1:0] hw_irq,
  output logic [XLEN-1:0] mip_rd,
  output logic [XLEN-1:0] mie_rd,
  output logic [XLEN-1:0] deleg_rd,
  output logic [XLEN-1:0] sip_rd,
  output logic [XLEN-1:0] sie_rd
);
  logic [IRQW-1:0] pend_q, en_q, deleg_q;
  logic [IRQW-1:0] pend_all, sip_mask;

  assign sip_mask = IRQ_SSOFT & deleg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      deleg_q <= '0;
    end else begin
      if (we_mip)      pend_q <= wd & IRQ_SW_PEND;
      else if (we_sip) pend_q <= (pend_q & ~sip_mask) | (wd & sip_mask);
      if (we_mie)      en_q <= wd & IRQ_EN_WMASK;
      else if (we_sie) en_q <= (en_q & ~deleg_q) | (wd & deleg_q);
      if (we_deleg)    deleg_q <= wd & IRQ_DELEGABLE;
    end
  end

  assign pend_all = pend_q | (hw_irq & IRQ_HW_PEND);
  assign mip_rd   = XLEN'(pend_all);
  assign mie_rd   = XLEN'(en_q);
  assign deleg_rd = XLEN'(deleg_q);
  assign sip_rd   = XLEN'(pend_all & deleg_q);
  assign sie_rd   = XLEN'(en_q & deleg_q);

  // R4: machine pending write sets the two software bits as written
  assert_mip_sw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_mip |=> (mip_rd[1] == $past(wd[1]) && mip_rd[5] == $past(wd[5])));
  // R6: supervisor pending write with bit 1 undelegated leaves bit 1 alone
  assert_sip_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_sip && !deleg_rd[1]) |=> $stable(mip_rd[1]));
  // R6: supervisor pending write never moves the timer bit
  assert_sip_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_sip |=> $stable(mip_rd[5]));
endmodule

// File: rtl/hsc_trapvec.sv
module hsc_trapvec #(
  parameter int unsigned XLEN           = 64,
  parameter logic [31:0] EXC_DELEG_MASK = 32'h0000_B3FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_mtvec,
  input  logic            we_stvec,
  input  logic            we_medeleg,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] mtvec_rd,
  output logic [XLEN-1:0] stvec_rd,
  output logic [XLEN-1:0] medeleg_rd
);
  localparam logic [XLEN-1:0] MT_KEEP = ~XLEN'(2);
  localparam logic [XLEN-1:0] ST_KEEP = ~XLEN'(3);
  localparam logic [XLEN-1:0] EX_KEEP = XLEN'(EXC_DELEG_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mtvec_rd   <= '0;
      stvec_rd   <= '0;
      medeleg_rd <= '0;
    end else begin
      if (we_mtvec)   mtvec_rd   <= wdata & MT_KEEP;
      if (we_stvec)   stvec_rd   <= wdata & ST_KEEP;
      if (we_medeleg) medeleg_rd <= wdata & EX_KEEP;
    end
  end

  // R7: machine vector keeps the mode bit, drops bit 1
  assert_mtvec_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_mtvec |=> (!mtvec_rd[1] && mtvec_rd[0] == $past(wdata[0])));
  // R7: supervisor vector is word aligned after a write
  assert_stvec_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_stvec |=> (stvec_rd[1:0] == 2'b00));
endmodule

// File: rtl/hsc_isa.sv
module hsc_isa
  import hsc_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter logic [25:0] MAX_EXT = 26'h014112D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [25:0]     wd,
  output logic [XLEN-1:0] misa_rd
);
  localparam logic [25:0] TOGGLE = ISA_TOGGLE & MAX_EXT;
  localparam logic [1:0]  MXL    = (XLEN == 64) ? 2'd2 : 2'd1;

  logic [25:0] ext_q, wd_legal;

  always_comb begin
    wd_legal = wd;
    if (!wd[5]) wd_legal[3] = 1'b0;   // no double without single
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ext_q <= MAX_EXT;
    else if (we) ext_q <= (wd_legal & TOGGLE) | (ext_q & ~TOGGLE);
  end

  always_comb begin
    misa_rd = '0;
    misa_rd[XLEN-1:XLEN-2] = MXL;
    misa_rd[25:0] = ext_q;
  end

  // R8: clearing F also clears D
  assert_f_drops_d_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wd[5]) |=> !misa_rd[3]);
  // R8: the base integer letter never changes
  assert_base_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> $stable(misa_rd[8]));
endmodule

// File: rtl/hart_status_csrs.sv
module hart_status_csrs
  import hsc_pkg::*;
#(
  parameter int unsigned XLEN           = 64,
  parameter bit          HAS_XEXT       = 1'b1,
  parameter logic [25:0] MAX_EXT        = 26'h014112D,
  parameter logic [31:0] EXC_DELEG_MASK = 32'h0000_B3FF,
  parameter int unsigned HART_ID        = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv_lvl,
  input  logic            csr_rd,
  input  logic            csr_wr,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [IRQW-1:0] hw_irq,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] misa_o,
  output logic [XLEN-1:0] medeleg_o,
  output logic [XLEN-1:0] mideleg_o,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] stvec_o
);
  reg_id_e         sel;
  logic            wr_ok;
  logic [XLEN-1:0] sstatus_v, sip_v, sie_v, rd_mux;

  // access check: existence, privilege, read-only space
  assign sel = csr_lookup(csr_addr);
  assign csr_illegal = (csr_rd || csr_wr) &&
                       ((sel == R_NONE) || (priv_lvl < csr_addr[9:8]) ||
                        (csr_wr && csr_addr[11:10] == 2'b11));
  assign wr_ok = csr_wr && !csr_illegal;

  hsc_status #(.XLEN(XLEN), .HAS_XEXT(HAS_XEXT)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_m       (wr_ok && sel == R_MSTATUS),
    .we_s       (wr_ok && sel == R_SSTATUS),
    .wdata      (csr_wdata),
    .mstatus_rd (mstatus_o),
    .sstatus_rd (sstatus_v)
  );

  hsc_irq #(.XLEN(XLEN)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_mip   (wr_ok && sel == R_MIP),
    .we_mie   (wr_ok && sel == R_MIE),
    .we_deleg (wr_ok && sel == R_MIDELEG),
    .we_sip   (wr_ok && sel == R_SIP),
    .we_sie   (wr_ok && sel == R_SIE),
    .wd       (csr_wdata[IRQW-1:0]),
    .hw_irq   (hw_irq),
    .mip_rd   (mip_o),
    .mie_rd   (mie_o),
    .deleg_rd (mideleg_o),
    .sip_rd   (sip_v),
    .sie_rd   (sie_v)
  );

  hsc_trapvec #(.XLEN(XLEN), .EXC_DELEG_MASK(EXC_DELEG_MASK)) u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_mtvec   (wr_ok && sel == R_MTVEC),
    .we_stvec   (wr_ok && sel == R_STVEC),
    .we_medeleg (wr_ok && sel == R_MEDELEG),
    .wdata      (csr_wdata),
    .mtvec_rd   (mtvec_o),
    .stvec_rd   (stvec_o),
    .medeleg_rd (medeleg_o)
  );

  hsc_isa #(.XLEN(XLEN), .MAX_EXT(MAX_EXT)) u_isa (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_ok && sel == R_MISA),
    .wd      (csr_wdata[25:0]),
    .misa_rd (misa_o)
  );

  always_comb begin
    case (sel)
      R_MSTATUS: rd_mux = mstatus_o;
      R_MISA:    rd_mux = misa_o;
      R_MEDELEG: rd_mux = medeleg_o;
      R_MIDELEG: rd_mux = mideleg_o;
      R_MIE:     rd_mux = mie_o;
      R_MTVEC:   rd_mux = mtvec_o;
      R_MIP:     rd_mux = mip_o;
      R_SSTATUS: rd_mux = sstatus_v;
      R_SIE:     rd_mux = sie_v;
      R_STVEC:   rd_mux = stvec_o;
      R_SIP:     rd_mux = sip_v;
      R_HART:    rd_mux = XLEN'(HART_ID);
      default:   rd_mux = '0;   // ID registers other than hart read zero
    endcase
  end

  assign csr_rdata = (csr_rd && !csr_illegal) ? rd_mux : '0;

  // R11: a refused write leaves every stored register unchanged
  assert_refused_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_illegal) |=> ($stable(mstatus_o) && $stable(misa_o) &&
      $stable(medeleg_o) && $stable(mideleg_o) && $stable(mie_o) &&
      $stable(mtvec_o) && $stable(stvec_o)));
  // R11: a lower privilege never reaches a machine register
  assert_priv_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_rd || csr_wr) && priv_lvl != 2'd3 && csr_addr[9:8] == 2'd3) |-> csr_illegal);
endmodule

// File: tb/sim_hart_status_csrs.sv
module sim_hart_status_csrs;
  localparam int XL = 64;
  localparam int HID = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    priv_lvl = 2'd3;
  logic          csr_rd = 1'b0, csr_wr = 1'b0;
  logic [11:0]   csr_addr = '0;
  logic [XL-1:0] csr_wdata = '0;
  logic [12:0]   hw_irq = '0;
  logic [XL-1:0] csr_rdata, mstatus_o, misa_o, medeleg_o, mideleg_o;
  logic [XL-1:0] mie_o, mip_o, mtvec_o, stvec_o;
  logic          csr_illegal;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;   // 50 MHz

  hart_status_csrs #(.XLEN(XL), .HART_ID(HID)) u0 (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .csr_rd(csr_rd),
    .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .hw_irq(hw_irq), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .mstatus_o(mstatus_o), .misa_o(misa_o), .medeleg_o(medeleg_o),
    .mideleg_o(mideleg_o), .mie_o(mie_o), .mip_o(mip_o),
    .mtvec_o(mtvec_o), .stvec_o(stvec_o)
  );

  typedef struct packed {
    logic          wr;
    logic [11:0]   waddr;
    logic [XL-1:0] wdata;
    logic [11:0]   raddr;
    logic [XL-1:0] exp;
    logic [7:0]    req;
  } vec_t;

  localparam logic [XL-1:0] ONES = {XL{1'b1}};
  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h300, ONES,           12'h300, 64'h8000_000A_007F_F9AA, 8'd3},  // R3 R1 R2
    '{1'b1, 12'h300, 64'h2000,       12'h300, 64'h0000_000A_0000_2000, 8'd1},  // R1
    '{1'b1, 12'h300, 64'h6000,       12'h300, 64'h8000_000A_0000_6000, 8'd1},  // R1 float-state
    '{1'b1, 12'h300, 64'h18000,      12'h100, 64'h8000_0002_0001_8000, 8'd9},  // R9 R1 ext-state
    '{1'b1, 12'h100, ONES,           12'h300, 64'h8000_000A_000D_E122, 8'd9},  // R9 write reach
    '{1'b0, 12'h000, 64'h0,          12'h100, 64'h8000_0002_0005_E122, 8'd9},  // R9 read view
    '{1'b1, 12'h300, 64'h0,          12'h300, 64'h0000_000A_0000_0000, 8'd2},  // R2
    '{1'b1, 12'h303, ONES,           12'h303, 64'h1222,                8'd5},  // R5
    '{1'b1, 12'h304, ONES,           12'h304, 64'h1AAA,                8'd5},  // R5
    '{1'b1, 12'h344, ONES,           12'h344, 64'h22,                  8'd4},  // R4
    '{1'b1, 12'h303, 64'h20,         12'h104, 64'h20,                  8'd6},  // R6 sie view
    '{1'b1, 12'h104, 64'h0,          12'h304, 64'h1A8A,                8'd6},  // R6 sie write
    '{1'b1, 12'h144, 64'h0,          12'h344, 64'h22,                  8'd6},  // R6 undelegated
    '{1'b1, 12'h303, 64'h2,          12'h144, 64'h2,                   8'd6},  // R6 sip view
    '{1'b1, 12'h144, 64'h0,          12'h344, 64'h20,                  8'd6},  // R6 sip clears
    '{1'b1, 12'h303, ONES,           12'h303, 64'h1222,                8'd5},  // R5
    '{1'b1, 12'h344, 64'h0,          12'h344, 64'h0,                   8'd4},  // R4
    '{1'b1, 12'h144, ONES,           12'h344, 64'h2,                   8'd6},  // R6 timer blocked
    '{1'b1, 12'h105, 64'h8000_1237,  12'h105, 64'h8000_1234,           8'd7},  // R7
    '{1'b1, 12'h305, 64'h8000_1237,  12'h305, 64'h8000_1235,           8'd7},  // R7
    '{1'b1, 12'h305, 64'h1002,       12'h305, 64'h1000,                8'd7},  // R7
    '{1'b1, 12'h301, 64'h0,          12'h301, 64'h8000_0000_0014_0100, 8'd8},  // R8
    '{1'b1, 12'h301, ONES,           12'h301, 64'h8000_0000_0014_112D, 8'd8},  // R8
    '{1'b1, 12'h301, 64'h1008,       12'h301, 64'h8000_0000_0014_1100, 8'd8},  // R8 F=0 drops D
    '{1'b1, 12'h302, ONES,           12'h302, 64'hB3FF,                8'd12}, // R12
    '{1'b0, 12'h000, 64'h0,          12'hF11, 64'h0,                   8'd10}, // R10
    '{1'b0, 12'h000, 64'h0,          12'hF12, 64'h0,                   8'd10}, // R10
    '{1'b0, 12'h000, 64'h0,          12'hF13, 64'h0,                   8'd10}, // R10
    '{1'b0, 12'h000, 64'h0,          12'hF14, 64'(HID),                8'd10}  // R10
  };

  task automatic check(input logic [XL-1:0] act, input logic [XL-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [XL-1:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [XL-1:0] d, output logic ill);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    #2;
    d = csr_rdata; ill = csr_illegal;
    @(negedge clk);
    csr_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [XL-1:0] d;
    logic ill;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    rd(12'h300, d, ill); check(d, 64'h0000_000A_0000_0000, "R13 mstatus");
    rd(12'h301, d, ill); check(d, 64'h8000_0000_0014_112D, "R13 misa");
    check(mie_o, 64'h0, "R13 mie");
    check(mtvec_o, 64'h0, "R13 mtvec");
    check({63'h0, ill}, 64'h0, "R13 no illegal");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, d, ill);
      check(d, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end
    check(mip_o, 64'h2, "R4 mip pin");

    // R4 hardware lines appear on the read-only pending bits
    hw_irq = 13'h1FFF;
    rd(12'h344, d, ill); check(d, 64'h1A8A, "R4 hw pending");
    wr(12'h344, ONES);
    rd(12'h344, d, ill); check(d, 64'h1AAA, "R4 hw plus sw");
    rd(12'h144, d, ill); check(d, 64'h1222, "R6 sip masked");
    hw_irq = 13'h0;

    // R11 privilege and address checks
    priv_lvl = 2'd1;
    rd(12'h300, d, ill);
    check({63'h0, ill}, 64'h1, "R11 S reads mstatus flag");
    check(d, 64'h0, "R11 S reads mstatus data");
    rd(12'h100, d, ill);
    check({63'h0, ill}, 64'h0, "R11 S reads sstatus");
    check(d, 64'h0000_0002_0000_0000, "R9 sstatus from S");
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = 12'h300; csr_wdata = ONES;
    #2 check({63'h0, csr_illegal}, 64'h1, "R11 S writes mstatus flag");
    @(negedge clk); csr_wr = 1'b0;
    priv_lvl = 2'd0;
    rd(12'h100, d, ill); check({63'h0, ill}, 64'h1, "R11 U reads sstatus");
    priv_lvl = 2'd3;
    rd(12'h300, d, ill); check(d, 64'h0000_000A_0000_0000, "R11 denied write ignored");
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = 12'hF14; csr_wdata = 64'h55;
    #2 check({63'h0, csr_illegal}, 64'h1, "R11 write read-only space");
    @(negedge clk); csr_wr = 1'b0;
    rd(12'hF14, d, ill); check(d, 64'(HID), "R11 hart id unchanged");
    rd(12'h7C0, d, ill); check({63'h0, ill}, 64'h1, "R11 unimplemented");
    check(d, 64'h0, "R11 unimplemented data");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule